// File: doc/BRIEF.md
# Dual-Bank Flash Erase Request Controller

This block sits between software-visible control and status registers and a two-bank flash array. Software selects one or both banks in a control register and sets a start bit. The controller decides in the same cycle whether the request is legal. Legality depends on the dual-bank mode input, on error flags left over from an earlier operation, and on the write-protect indication of each selected bank. A legal request pulses an erase strobe for each selected bank and starts a per-bank duration timer. Busy and the start bit then stay high until the array reports completion. An illegal request raises a sticky error flag and erases nothing.

Both banks erase in parallel when both are selected. A write-protect hit in either selected bank aborts the request for both banks. While an operation runs, the controller requests the internal oscillator, unless software has already turned that oscillator on. Error flags persist until software writes a one to the matching status bit.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, the control readback, the status readback, busy, both erase strobes and the oscillator request are all zero.
- R2: A start that is accepted pulses the strobes for one cycle, in the cycle after the write. Busy and control bit 7 (start) are then high for exactly ERASE_CYCLES cycles and clear together.
- R3: When dual-bank mode is on and only one bank is selected (control bit 0 = bank A, bit 1 = bank B), only that bank's strobe pulses.
- R4: When both bank bits are set, both strobes pulse together, whatever the mode.
- R5: When dual-bank mode is off and exactly one bank bit is set, start sets the sequence-error flag (status bit 1). No strobe pulses and busy stays low.
- R6: A start with neither bank bit set sets the sequence-error flag and performs no erase.
- R7: If the sequence-error flag or the protect-error flag is already set when start is written, the sequence-error flag is set and no erase occurs.
- R8: If any selected bank has its write-protect input high, the protect-error flag (status bit 2) is set and neither bank's strobe pulses.
- R9: A write to the control register while busy is high has no effect: the bank bits keep their values, no new strobe pulses, and the running operation keeps its length.
- R10: Writing a one to status bit 1 or bit 2 clears that flag. Writing a zero leaves it as it was. Status bit 0 reads busy.
- R11: The oscillator request is high exactly while an accepted operation runs and the software oscillator-enable input is low.
- R12: After a rejected start, control bit 7 reads zero in the next cycle, and the bank bits read as they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control, 1 status |
| reg_wdata | input | 8 | Write data |
| dual_bank | input | 1 | Dual-bank mode enable |
| wp_hit | input | 2 | Per-bank write-protect present (bit 0 bank A) |
| osc_sw_on | input | 1 | Oscillator already enabled by software |
| ctrl_rd | output | 8 | Control readback: bit 7 start, bits 1:0 bank selects |
| stat_rd | output | 8 | Status readback: bit 2 protect error, bit 1 sequence error, bit 0 busy |
| busy | output | 1 | Erase in progress |
| erase_pulse | output | 2 | One-cycle erase strobe per bank |
| osc_req | output | 1 | Internal oscillator request |

## Verification
Every result of a control write is due one clock edge after the edge that samples the write. The strobes, the error flags, the start readback and the start of busy all appear then. The fall of busy comes ERASE_CYCLES edges after that. The bench drives on falling edges, and on the falling edge after the write it samples strobes, flags and readback. It then counts falling edges while busy stays high and compares the count to ERASE_CYCLES. A write made during busy is checked by that same count and by the unchanged bank bits afterwards.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam int REG_W     = 8;
  localparam int NUM_BANKS = 2;

  localparam int CTL_SEL_A = 0;
  localparam int CTL_SEL_B = 1;
  localparam int CTL_GO    = 7;

  localparam int STS_BUSY  = 0;
  localparam int STS_SEQ   = 1;
  localparam int STS_WP    = 2;

  typedef enum logic [1:0] {
    VERDICT_RUN = 2'd0,
    VERDICT_SEQ = 2'd1,
    VERDICT_WP  = 2'd2
  } verdict_e;

  // Priority: leftover flags, then empty selection, then single bank in
  // single-bank mode, then protection.
  function automatic verdict_e judge(input logic [NUM_BANKS-1:0] sel,
                                     input logic dual,
                                     input logic leftover,
                                     input logic [NUM_BANKS-1:0] wp);
    if (leftover)                         return VERDICT_SEQ;
    if (sel == '0)                        return VERDICT_SEQ;
    if (!dual && (sel != '1))             return VERDICT_SEQ;
    if ((sel & wp) != '0)                 return VERDICT_WP;
    return VERDICT_RUN;
  endfunction

  function automatic logic [REG_W-1:0] pack_ctrl(input logic go,
                                                 input logic [NUM_BANKS-1:0] sel);
    logic [REG_W-1:0] r;
    r = '0;
    r[CTL_GO]    = go;
    r[CTL_SEL_A] = sel[0];
    r[CTL_SEL_B] = sel[1];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic bsy,
                                                   input logic seq,
                                                   input logic wpe);
    logic [REG_W-1:0] r;
    r = '0;
    r[STS_BUSY] = bsy;
    r[STS_SEQ]  = seq;
    r[STS_WP]   = wpe;
    return r;
  endfunction

endpackage

// File: rtl/erase_req_check.sv
module erase_req_check
  import flash_erase_pkg::*;
(
  input  logic                 go_write,
  input  logic [NUM_BANKS-1:0] sel,
  input  logic                 dual,
  input  logic                 leftover,
  input  logic [NUM_BANKS-1:0] wp,
  output logic                 accept,
  output logic                 raise_seq,
  output logic                 raise_wp
);
  verdict_e v;

  always_comb begin
    v         = judge(sel, dual, leftover, wp);
    accept    = go_write && (v == VERDICT_RUN);
    raise_seq = go_write && (v == VERDICT_SEQ);
    raise_wp  = go_write && (v == VERDICT_WP);
  end
endmodule

// File: rtl/erase_bank_timer.sv
module erase_bank_timer #(
  parameter int ERASE_CYCLES = 40,
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active,
  output logic last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (start)         cnt_q <= CNT_W'(ERASE_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int ERASE_CYCLES = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 dual_bank,
  input  logic [NUM_BANKS-1:0] wp_hit,
  input  logic                 osc_sw_on,
  output logic [REG_W-1:0]     ctrl_rd,
  output logic [REG_W-1:0]     stat_rd,
  output logic                 busy,
  output logic [NUM_BANKS-1:0] erase_pulse,
  output logic                 osc_req
);
  logic [NUM_BANKS-1:0] sel_q, pulse_q, bank_active, bank_last, wr_sel;
  logic                 go_q, seq_q, wpe_q;
  logic                 ctrl_wr, stat_wr, go_write;
  logic                 accept, raise_seq, raise_wp;
  logic                 array_done;
  logic                 unused_wdata;

  assign busy     = |bank_active;
  assign ctrl_wr  = reg_wr && !reg_sel && !busy;
  assign stat_wr  = reg_wr && reg_sel;
  assign go_write = ctrl_wr && reg_wdata[CTL_GO];
  assign wr_sel   = {reg_wdata[CTL_SEL_B], reg_wdata[CTL_SEL_A]};
  assign unused_wdata = ^{reg_wdata[6:3]};

  erase_req_check u_check (
    .go_write (go_write),
    .sel      (wr_sel),
    .dual     (dual_bank),
    .leftover (seq_q || wpe_q),
    .wp       (wp_hit),
    .accept   (accept),
    .raise_seq(raise_seq),
    .raise_wp (raise_wp)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    erase_bank_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept && wr_sel[b]),
      .active(bank_active[b]),
      .last  (bank_last[b])
    );
  end

  // Done when every running bank is on its final cycle.
  assign array_done = busy && ((~bank_active | bank_last) == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      go_q    <= 1'b0;
      pulse_q <= '0;
      seq_q   <= 1'b0;
      wpe_q   <= 1'b0;
    end else begin
      if (ctrl_wr) sel_q <= wr_sel;
      if (accept)          go_q <= 1'b1;
      else if (array_done) go_q <= 1'b0;
      pulse_q <= accept ? wr_sel : '0;
      if (raise_seq)                       seq_q <= 1'b1;
      else if (stat_wr && reg_wdata[STS_SEQ]) seq_q <= 1'b0;
      if (raise_wp)                        wpe_q <= 1'b1;
      else if (stat_wr && reg_wdata[STS_WP])  wpe_q <= 1'b0;
    end
  end

  assign erase_pulse = pulse_q;
  assign osc_req     = go_q && !osc_sw_on;
  assign ctrl_rd     = pack_ctrl(go_q, sel_q);
  assign stat_rd     = pack_status(busy, seq_q, wpe_q);
endmodule

// File: rtl/flash_erase_ctrl_sva.sv
module flash_erase_ctrl_sva
  import flash_erase_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic                 reg_sel,
  input logic [REG_W-1:0]     reg_wdata,
  input logic                 dual_bank,
  input logic [NUM_BANKS-1:0] wp_hit,
  input logic                 osc_sw_on,
  input logic [REG_W-1:0]     ctrl_rd,
  input logic [REG_W-1:0]     stat_rd,
  input logic                 busy,
  input logic [NUM_BANKS-1:0] erase_pulse,
  input logic                 osc_req
);
  logic go_wr_idle;
  assign go_wr_idle = reg_wr && !reg_sel && reg_wdata[CTL_GO] && !busy;

  AST_PULSE_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_pulse != '0) |-> busy); // R2
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_pulse != '0) |=> (erase_pulse == '0)); // R2
  AST_GO_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[CTL_GO] == busy); // R2
  AST_SINGLE_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr_idle && !dual_bank && $countones(reg_wdata[1:0]) == 1)
      |=> (erase_pulse == '0) && stat_rd[STS_SEQ] && !busy); // R5
  AST_EMPTY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr_idle && reg_wdata[1:0] == 2'b00) |=> (erase_pulse == '0) && stat_rd[STS_SEQ]); // R6
  AST_PROTECT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr_idle && (reg_wdata[1:0] & wp_hit) != '0) |=> (erase_pulse == '0) && !busy); // R8
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && !reg_sel) |=> $stable(ctrl_rd[1:0]) && (erase_pulse == '0)); // R9
  AST_W1C_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && reg_wdata[STS_SEQ]) |=> !stat_rd[STS_SEQ]); // R10
  AST_OSC_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !osc_sw_on) |-> osc_req); // R11
  AST_OSC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || osc_sw_on) |-> !osc_req); // R11
endmodule

bind flash_erase_ctrl flash_erase_ctrl_sva u_sva (.*);

// File: tb/flash_erase_ctrl_test.sv
module flash_erase_ctrl_test;
  localparam int N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       dual_bank = 1'b0;
  logic [1:0] wp_hit = '0;
  logic       osc_sw_on = 1'b0;
  logic [7:0] ctrl_rd, stat_rd;
  logic       busy, osc_req;
  logic [1:0] erase_pulse;

  int checks = 0;
  int fails  = 0;
  bit seq_m = 0, wpe_m = 0;

  always #2 clk = ~clk;

  flash_erase_ctrl #(.ERASE_CYCLES(N)) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 = run, 1 = sequence error, 2 = protect error
  function automatic int expect_verdict(input bit [1:0] s, input bit d,
                                        input bit [1:0] wp);
    if (seq_m || wpe_m) return 1;
    case (s)
      2'b00: return 1;
      2'b11: return (wp != 0) ? 2 : 0;
      default: begin
        if (!d) return 1;
        return ((s & wp) != 0) ? 2 : 0;
      end
    endcase
  endfunction

  task automatic wr(input bit s, input bit [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic clear_flags(input bit [1:0] which);
    wr(1'b1, {5'b0, which, 1'b0});
    if (which[0]) seq_m = 0;
    if (which[1]) wpe_m = 0;
  endtask

  task automatic start_op(input bit [1:0] s, input bit d, input bit [1:0] wp,
                          input bit sw, input bit poke);
    int v, n;
    v = expect_verdict(s, d, wp);
    @(negedge clk);
    dual_bank = d; wp_hit = wp; osc_sw_on = sw;
    wr(1'b0, {1'b1, 5'b0, s});
    if (v == 0) begin
      chk(erase_pulse == s, (s == 2'b11) ? "R4 both strobes" : "R3 single strobe",
          erase_pulse, s);
      chk(busy && ctrl_rd[7], "R2 busy and start high", {busy, ctrl_rd[7]}, 3);
      chk(osc_req == !sw, "R11 oscillator request", osc_req, !sw);
      n = 0;
      while (busy && n < 1000) begin
        if (poke && n == 2) begin
          reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 8'h80 | {6'b0, ~s};
          @(negedge clk);
          reg_wr = 1'b0; reg_wdata = '0;
          chk(erase_pulse == 0, "R9 no strobe while busy", erase_pulse, 0);
          n++;
        end else begin
          @(negedge clk);
          n++;
        end
      end
      chk(n == N, poke ? "R9 busy length kept" : "R2 busy length", n, N);
      chk(ctrl_rd == {6'b0, s}, poke ? "R9 selects kept" : "R2 start cleared",
          ctrl_rd, {6'b0, s});
      chk(!osc_req, "R11 oscillator released", osc_req, 0);
    end else begin
      if (v == 1) seq_m = 1; else wpe_m = 1;
      chk(erase_pulse == 0 && !busy, (v == 2) ? "R8 no erase" : "R5 R6 R7 no erase",
          {busy, erase_pulse}, 0);
      chk(stat_rd[2:1] == {wpe_m, seq_m}, (v == 2) ? "R8 protect flag" : "R7 sequence flag",
          stat_rd[2:1], {wpe_m, seq_m});
      chk(ctrl_rd == {6'b0, s}, "R12 start self-cleared", ctrl_rd, {6'b0, s});
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(ctrl_rd == 0 && stat_rd == 0 && !busy && erase_pulse == 0 && !osc_req,
        "R1 reset state", {ctrl_rd, stat_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    start_op(2'b01, 1, 2'b00, 0, 0);          // R3 bank A
    start_op(2'b10, 1, 2'b01, 1, 0);          // R3 bank B, other bank protected
    start_op(2'b11, 0, 2'b00, 0, 0);          // R4 mass erase, single mode
    start_op(2'b01, 0, 2'b00, 0, 0);          // R5
    start_op(2'b11, 1, 2'b00, 0, 0);          // R7 leftover flag blocks
    wr(1'b1, 8'h00);
    chk(stat_rd[1] == 1, "R10 zero write keeps flag", stat_rd[1], 1);
    clear_flags(2'b01);
    chk(stat_rd[1] == 0, "R10 one write clears flag", stat_rd[1], 0);
    start_op(2'b00, 1, 2'b00, 0, 0);          // R6
    clear_flags(2'b11);
    start_op(2'b11, 1, 2'b10, 0, 0);          // R8 abort both
    clear_flags(2'b01);
    chk(stat_rd[2:1] == 2'b10, "R10 selective clear", stat_rd[2:1], 2'b10);
    clear_flags(2'b11);
    start_op(2'b10, 1, 2'b00, 0, 1);          // R9 write during busy

    for (int i = 0; i < 80; i++) begin
      bit [1:0] s, wp;
      bit d, sw;
      s  = 2'($urandom_range(0, 3));
      d  = 1'($urandom_range(0, 1));
      sw = 1'($urandom_range(0, 1));
      wp = {($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0)};
      if ($urandom_range(0, 2) != 0) clear_flags(2'b11);
      start_op(s, d, wp, sw, ($urandom_range(0, 4) == 0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule